// File: doc/BRIEF.md
# EPROM Programming Sequencer

This block burns a byte image into one of several UV-erasable PROM devices that share an address bus, a data bus, an output-enable line and a programming-voltage line. Software or a loader supplies a stream of (device, address, byte) records after a start command. For each record the sequencer first reads the location back. A location that already holds the byte is skipped. A byte that would need a 0 turned back into a 1 is refused and flagged, since only erasure can set a bit. Otherwise the sequencer programs the location. It puts address and data on the pins, requests the high programming voltage, waits a setup interval and drives one bounded active-low pulse on the selected device's chip enable. It then holds, drops the voltage, waits a recovery interval and performs a verify read.

Devices that are not selected keep their chip enables high for the whole sequence, which inhibits them while the programming voltage is shared. All intervals are parameters counted in clock cycles. The defaults suit a 250 MHz clock: 2 us of setup and a 50 ms pulse inside a 45 to 55 ms window. Status is kept as sticky flags that hold the first failing address of each kind until the next start.

Top module: `prom_burn_seq`

## Requirements
- R1: After reset all chip enables and the output enable are high (1), the voltage request and the data drive enable are low (0), and busy, done, fail and unprog are 0.
- R2: A start in idle clears fail and unprog and raises busy. Records are accepted one per pair_valid/pair_ready handshake. After the record marked pair_last is finished, done is high for exactly one cycle and busy returns low.
- R3: Each record begins with a read of the location (selected chip enable low, output enable low, data drive off). When the read value equals the requested byte, no program pulse is applied.
- R4: When the requested byte has a 1 in a bit where the read value has a 0, no pulse is applied. unprog is set, and unprog_addr holds the address of the first such record since start.
- R5: Before a program pulse, vpp_en and prom_dq_oe are high and prom_addr and prom_dq_out are stable for at least SETUP_CYC cycles. They stay stable while the chip enable is low.
- R6: A program pulse is one low period of exactly PULSE_CYC cycles on one chip enable, with vpp_en high and output enable high. It always lies within PULSE_MIN to PULSE_MAX cycles.
- R7: Only the chip enable of the device in the record's pair_dev field goes low; every other chip enable stays high throughout.
- R8: After a pulse, the chip enable and vpp_en are released, and vpp_en stays low for at least SETUP_CYC cycles before the verify read pulls the output enable low.
- R9: A verify read that differs from the requested byte sets fail, and fail_addr holds the first such address since start. The sequence continues with the next record.
- R10: prom_dq_oe is never high while prom_oe_n is low, and after each read all enables stay high for REL_CYC cycles.
- R11: Records may target any address in any order. Each programmed location receives exactly one pulse per record, after which it reads back the requested byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming session (honoured in idle) |
| pair_valid | input | 1 | Record available |
| pair_ready | output | 1 | Sequencer takes the record this cycle |
| pair_addr | input | ADDR_W | Target location |
| pair_data | input | DATA_W | Requested byte |
| pair_dev | input | DEV_W | Target device index |
| pair_last | input | 1 | Final record of the session |
| prom_dq_in | input | DATA_W | Data read back from the device bus |
| prom_addr | output | ADDR_W | Device address bus |
| prom_dq_out | output | DATA_W | Data driven to the device bus |
| prom_dq_oe | output | 1 | Enable for driving prom_dq_out |
| prom_ce_n | output | NDEV | Per-device active-low chip enables |
| prom_oe_n | output | 1 | Shared active-low output enable |
| vpp_en | output | 1 | Request for the high programming voltage |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle end-of-session strobe |
| fail | output | 1 | Sticky verify mismatch flag |
| fail_addr | output | ADDR_W | First verify-mismatch address |
| unprog | output | 1 | Sticky unprogrammable-byte flag |
| unprog_addr | output | ADDR_W | First unprogrammable address |

## Verification
The assertions check several properties on every cycle: that no more than one chip enable is active, that data is never driven while the output enable is low, that the voltage request is held for the setup time before a pulse, that it has been off for the recovery time before any verify read, and that each pulse width lies inside the allowed window. They also check that the sticky flags and their addresses do not change within a session. Only the bench's scenarios can show the decisions made per record against a device model. Those decisions are skipping equal bytes, refusing 0-to-1 requests, catching a stuck bit at verify, taking the first failing address, and counting pulses per device. The same holds for the final memory image after random record streams and for the single done strobe.

// File: rtl/prom_burn_pkg.sv
package prom_burn_pkg;

  typedef enum logic [3:0] {
    S_IDLE   = 4'd0,
    S_TAKE   = 4'd1,
    S_PRERD  = 4'd2,
    S_GAP    = 4'd3,
    S_SETUP  = 4'd4,
    S_PULSE  = 4'd5,
    S_HOLD   = 4'd6,
    S_RECOV  = 4'd7,
    S_VERIFY = 4'd8,
    S_DONE   = 4'd9
  } burn_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prom_burn_timer.sv
module prom_burn_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/prom_burn_ctl.sv
module prom_burn_ctl
  import prom_burn_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int DEV_W     = 1,
  parameter int CNT_W     = 24,
  parameter int SETUP_CYC = 500,
  parameter int PULSE_CYC = 12500000,
  parameter int ACC_CYC   = 64,
  parameter int REL_CYC   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pair_valid,
  output logic              pair_ready,
  input  logic [ADDR_W-1:0] pair_addr,
  input  logic [DATA_W-1:0] pair_data,
  input  logic [DEV_W-1:0]  pair_dev,
  input  logic              pair_last,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output burn_state_t       state,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [DEV_W-1:0]  dev_q,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic              unprog,
  output logic [ADDR_W-1:0] unprog_addr
);

  localparam logic [CNT_W-1:0] SETUP_M1 = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_M1 = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] ACC_M1   = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] REL_M1   = CNT_W'(REL_CYC - 1);

  burn_state_t       st_q, st_d;
  logic              last_q, need_q, need_d;
  logic              fail_q, fail_d, unp_q, unp_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d, uaddr_q, uaddr_d;
  logic              take;
  logic              flag_en;

  // next-state and timer load
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    take     = 1'b0;
    unique case (st_q)
      S_IDLE:   if (start) st_d = S_TAKE;
      S_TAKE: begin
        if (pair_valid) begin
          take     = 1'b1;
          st_d     = S_PRERD;
          tmr_load = 1'b1;
          tmr_val  = ACC_M1;
        end
      end
      S_PRERD: begin
        if (tmr_zero) begin
          st_d = S_GAP; tmr_load = 1'b1; tmr_val = REL_M1;
        end
      end
      S_GAP: begin
        if (tmr_zero) begin
          if (need_q) begin
            st_d = S_SETUP; tmr_load = 1'b1; tmr_val = SETUP_M1;
          end else if (last_q) begin
            st_d = S_DONE;
          end else begin
            st_d = S_TAKE;
          end
        end
      end
      S_SETUP: begin
        if (tmr_zero) begin
          st_d = S_PULSE; tmr_load = 1'b1; tmr_val = PULSE_M1;
        end
      end
      S_PULSE: begin
        if (tmr_zero) begin
          st_d = S_HOLD; tmr_load = 1'b1; tmr_val = SETUP_M1;
        end
      end
      S_HOLD: begin
        if (tmr_zero) begin
          st_d = S_RECOV; tmr_load = 1'b1; tmr_val = SETUP_M1;
        end
      end
      S_RECOV: begin
        if (tmr_zero) begin
          st_d = S_VERIFY; tmr_load = 1'b1; tmr_val = ACC_M1;
        end
      end
      S_VERIFY: begin
        if (tmr_zero) begin
          st_d = S_GAP; tmr_load = 1'b1; tmr_val = REL_M1;
        end
      end
      S_DONE:   st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  // per-record decisions and sticky flags
  always_comb begin
    need_d  = need_q;
    fail_d  = fail_q;
    faddr_d = faddr_q;
    unp_d   = unp_q;
    uaddr_d = uaddr_q;
    if (st_q == S_IDLE && start) begin
      fail_d = 1'b0;
      unp_d  = 1'b0;
    end
    if (st_q == S_PRERD && tmr_zero) begin
      if ((data_q & ~rd_data) != '0) begin
        need_d = 1'b0;
        if (!unp_q) begin
          unp_d   = 1'b1;
          uaddr_d = addr_q;
        end
      end else begin
        need_d = (rd_data != data_q);
      end
    end
    if (st_q == S_VERIFY && tmr_zero) begin
      need_d = 1'b0;
      if (rd_data != data_q && !fail_q) begin
        fail_d  = 1'b1;
        faddr_d = addr_q;
      end
    end
  end

  assign flag_en = (st_q == S_IDLE) || (st_q == S_PRERD) || (st_q == S_VERIFY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      dev_q  <= '0;
      last_q <= 1'b0;
    end else if (take) begin
      addr_q <= pair_addr;
      data_q <= pair_data;
      dev_q  <= pair_dev;
      last_q <= pair_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_q  <= 1'b0;
      fail_q  <= 1'b0;
      faddr_q <= '0;
      unp_q   <= 1'b0;
      uaddr_q <= '0;
    end else if (flag_en) begin
      need_q  <= need_d;
      fail_q  <= fail_d;
      faddr_q <= faddr_d;
      unp_q   <= unp_d;
      uaddr_q <= uaddr_d;
    end
  end

  assign state       = st_q;
  assign pair_ready  = (st_q == S_TAKE);
  assign busy        = (st_q != S_IDLE);
  assign done        = (st_q == S_DONE);
  assign fail        = fail_q;
  assign fail_addr   = faddr_q;
  assign unprog      = unp_q;
  assign unprog_addr = uaddr_q;

  // R9: fail flag and its address hold until the next start
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !(st_q == S_IDLE && start)) |=> (fail_q && $stable(faddr_q)));

  // R4: unprog flag and its address hold until the next start
  a_r4_unprog_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (unp_q && !(st_q == S_IDLE && start)) |=> (unp_q && $stable(uaddr_q)));

  // R2: done lasts one cycle and is followed by idle
  a_r2_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

// File: rtl/prom_burn_pins.sv
module prom_burn_pins
  import prom_burn_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int NDEV      = 2,
  parameter int DEV_W     = 1,
  parameter int SETUP_CYC = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burn_state_t       state,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic [DEV_W-1:0]  dev_q,
  output logic [ADDR_W-1:0] prom_addr,
  output logic [DATA_W-1:0] prom_dq_out,
  output logic              prom_dq_oe,
  output logic [NDEV-1:0]   prom_ce_n,
  output logic              prom_oe_n,
  output logic              vpp_en
);

  localparam int AGE_W = $clog2(SETUP_CYC + 1);

  logic sel_phase, rd_phase, hv_phase;

  always_comb begin
    rd_phase  = (state == S_PRERD) || (state == S_VERIFY);
    sel_phase = rd_phase || (state == S_PULSE);
    hv_phase  = (state == S_SETUP) || (state == S_PULSE) || (state == S_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prom_addr   <= '0;
      prom_dq_out <= '0;
      prom_dq_oe  <= 1'b0;
      prom_oe_n   <= 1'b1;
      vpp_en      <= 1'b0;
    end else begin
      prom_addr   <= addr_q;
      prom_dq_out <= data_q;
      prom_dq_oe  <= hv_phase;
      prom_oe_n   <= !rd_phase;
      vpp_en      <= hv_phase;
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_ce
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prom_ce_n[d] <= 1'b1;
      end else begin
        prom_ce_n[d] <= !(sel_phase && (dev_q == DEV_W'(d)));
      end
    end
  end

  // timing checkers: cycles with the voltage request on / off
  logic [AGE_W-1:0] hi_age, lo_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_age <= '0;
      lo_age <= AGE_W'(SETUP_CYC);
    end else begin
      if (!vpp_en)                         hi_age <= '0;
      else if (hi_age != AGE_W'(SETUP_CYC)) hi_age <= hi_age + AGE_W'(1);
      if (vpp_en)                          lo_age <= '0;
      else if (lo_age != AGE_W'(SETUP_CYC)) lo_age <= lo_age + AGE_W'(1);
    end
  end

  a_r10_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
    !(prom_dq_oe && !prom_oe_n));

  a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~prom_ce_n) <= 1);

  a_r5_setup_time: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(&prom_ce_n) && vpp_en) |-> (hi_age >= AGE_W'(SETUP_CYC)));

  a_r5_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_en && !(&prom_ce_n)) |=> ($stable(prom_addr) && $stable(prom_dq_out)));

  a_r8_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prom_oe_n) |-> (!vpp_en && lo_age >= AGE_W'(SETUP_CYC)));

  a_r6_pulse_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_en && !(&prom_ce_n)) |-> prom_oe_n);

endmodule

// File: rtl/prom_burn_seq.sv
module prom_burn_seq
  import prom_burn_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int NDEV      = 2,
  parameter int SETUP_CYC = 500,
  parameter int PULSE_CYC = 12500000,
  parameter int PULSE_MIN = 11250000,
  parameter int PULSE_MAX = 13750000,
  parameter int ACC_CYC   = 64,
  parameter int REL_CYC   = 40,
  localparam int DEV_W    = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pair_valid,
  output logic              pair_ready,
  input  logic [ADDR_W-1:0] pair_addr,
  input  logic [DATA_W-1:0] pair_data,
  input  logic [DEV_W-1:0]  pair_dev,
  input  logic              pair_last,
  input  logic [DATA_W-1:0] prom_dq_in,
  output logic [ADDR_W-1:0] prom_addr,
  output logic [DATA_W-1:0] prom_dq_out,
  output logic              prom_dq_oe,
  output logic [NDEV-1:0]   prom_ce_n,
  output logic              prom_oe_n,
  output logic              vpp_en,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic              unprog,
  output logic [ADDR_W-1:0] unprog_addr
);

  localparam int LONGEST = max2(max2(PULSE_CYC, SETUP_CYC), max2(ACC_CYC, REL_CYC));
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam int PW_W    = $clog2(PULSE_MAX + 2);

  burn_state_t       state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DEV_W-1:0]  dev_q;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;

  prom_burn_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  prom_burn_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_W(DEV_W), .CNT_W(CNT_W),
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .ACC_CYC(ACC_CYC), .REL_CYC(REL_CYC)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pair_valid(pair_valid), .pair_ready(pair_ready), .pair_addr(pair_addr),
    .pair_data(pair_data), .pair_dev(pair_dev), .pair_last(pair_last),
    .rd_data(prom_dq_in), .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .state(state), .addr_q(addr_q), .data_q(data_q), .dev_q(dev_q),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
    .unprog(unprog), .unprog_addr(unprog_addr)
  );

  prom_burn_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NDEV(NDEV), .DEV_W(DEV_W), .SETUP_CYC(SETUP_CYC)
  ) u_pins (
    .clk(clk), .rst_n(rst_n), .state(state), .addr_q(addr_q), .data_q(data_q),
    .dev_q(dev_q), .prom_addr(prom_addr), .prom_dq_out(prom_dq_out),
    .prom_dq_oe(prom_dq_oe), .prom_ce_n(prom_ce_n), .prom_oe_n(prom_oe_n),
    .vpp_en(vpp_en)
  );

  // pulse width window checker
  logic            prog_low;
  logic [PW_W-1:0] pw_cnt;

  assign prog_low = vpp_en && !(&prom_ce_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_cnt <= '0;
    end else if (!prog_low) begin
      pw_cnt <= '0;
    end else if (pw_cnt != PW_W'(PULSE_MAX + 1)) begin
      pw_cnt <= pw_cnt + PW_W'(1);
    end
  end

  a_r6_width_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_low) |-> (pw_cnt >= PW_W'(PULSE_MIN)));

  a_r6_width_max: assert property (@(posedge clk) disable iff (!rst_n)
    prog_low |-> (pw_cnt < PW_W'(PULSE_MAX)));

endmodule

// File: tb/sim_prom_burn_seq.sv
module sim_prom_burn_seq;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int ND = 2;
  localparam int NLOC = 1 << AW;
  localparam int T_SET = 5;
  localparam int T_PUL = 40;
  localparam int T_ACC = 3;
  localparam int T_REL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start = 1'b0, pair_valid = 1'b0, pair_last = 1'b0;
  logic [AW-1:0] pair_addr = '0;
  logic [DW-1:0] pair_data = '0;
  logic          pair_dev = 1'b0;
  logic          pair_ready, prom_dq_oe, prom_oe_n, vpp_en, busy, done, fail, unprog;
  logic [DW-1:0] prom_dq_in, prom_dq_out;
  logic [AW-1:0] prom_addr, fail_addr, unprog_addr;
  logic [ND-1:0] prom_ce_n;

  prom_burn_seq #(
    .ADDR_W(AW), .DATA_W(DW), .NDEV(ND), .SETUP_CYC(T_SET), .PULSE_CYC(T_PUL),
    .PULSE_MIN(36), .PULSE_MAX(44), .ACC_CYC(T_ACC), .REL_CYC(T_REL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pair_valid(pair_valid),
    .pair_ready(pair_ready), .pair_addr(pair_addr), .pair_data(pair_data),
    .pair_dev(pair_dev), .pair_last(pair_last), .prom_dq_in(prom_dq_in),
    .prom_addr(prom_addr), .prom_dq_out(prom_dq_out), .prom_dq_oe(prom_dq_oe),
    .prom_ce_n(prom_ce_n), .prom_oe_n(prom_oe_n), .vpp_en(vpp_en), .busy(busy),
    .done(done), .fail(fail), .fail_addr(fail_addr), .unprog(unprog),
    .unprog_addr(unprog_addr)
  );

  // device models
  logic [DW-1:0] mem   [ND][NLOC];
  logic [DW-1:0] stuck [ND][NLOC];
  logic [DW-1:0] exm   [ND][NLOC];

  always_comb begin
    prom_dq_in = '1;
    for (int d = 0; d < ND; d++)
      if (!prom_ce_n[d] && !prom_oe_n) prom_dq_in = mem[d][prom_addr];
  end

  int nchk = 0, nerr = 0;
  int pulses [ND];
  int low_cnt [ND];
  int vhi = 0, vlo = 1000;
  int v_setup = 0, v_width = 0, v_rec = 0, v_bus = 0, v_sel = 0, n_done = 0;
  logic prev_oe = 1'b1;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;

  // monitor, sampled on the falling edge
  always @(negedge clk) if (rst_n) begin
    if (prom_dq_oe && !prom_oe_n) v_bus++;
    if ($countones(~prom_ce_n) > 1) v_sel++;
    if (!prom_oe_n && prev_oe && (vlo < T_SET || vpp_en)) v_rec++;
    if (done) n_done++;
    for (int d = 0; d < ND; d++) begin
      if (!prom_ce_n[d] && vpp_en) begin
        if (low_cnt[d] == 0) begin
          if (vhi < T_SET || !prom_dq_oe) v_setup++;
          p_addr = prom_addr; p_data = prom_dq_out;
        end else if (prom_addr != p_addr || prom_dq_out != p_data) v_setup++;
        low_cnt[d]++;
      end else if (low_cnt[d] != 0) begin
        if (low_cnt[d] != T_PUL) v_width++;
        pulses[d]++;
        mem[d][p_addr] = mem[d][p_addr] & (p_data | stuck[d][p_addr]);
        low_cnt[d] = 0;
      end
    end
    prev_oe = prom_oe_n;
    vhi = vpp_en ? vhi + 1 : 0;
    vlo = vpp_en ? 0 : vlo + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // session record list and expected results
  int            s_n;
  logic          s_dev  [64];
  logic [AW-1:0] s_addr [64];
  logic [DW-1:0] s_data [64];
  logic          e_fail, e_unp;
  logic [AW-1:0] e_faddr, e_uaddr;
  int            e_pul [ND];

  task automatic new_session();
    s_n = 0; e_fail = 0; e_unp = 0; e_faddr = '0; e_uaddr = '0;
    for (int d = 0; d < ND; d++) e_pul[d] = 0;
  endtask

  task automatic add_pair(input logic d, input logic [AW-1:0] a, input logic [DW-1:0] w);
    logic [DW-1:0] cur, nv;
    s_dev[s_n] = d; s_addr[s_n] = a; s_data[s_n] = w; s_n++;
    cur = exm[d][a];
    if ((w & ~cur) != '0) begin
      if (!e_unp) begin e_unp = 1; e_uaddr = a; end
    end else if (cur != w) begin
      e_pul[d]++;
      nv = cur & (w | stuck[d][a]);
      exm[d][a] = nv;
      if (nv != w && !e_fail) begin e_fail = 1; e_faddr = a; end
    end
  endtask

  task automatic run_session(input string tag);
    int p0 [ND];
    int d0;
    for (int d = 0; d < ND; d++) p0[d] = pulses[d];
    d0 = n_done;
    v_setup = 0; v_width = 0; v_rec = 0; v_bus = 0; v_sel = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 busy after start"}, busy, 1);
    for (int i = 0; i < s_n; i++) begin
      pair_valid = 1'b1; pair_dev = s_dev[i]; pair_addr = s_addr[i];
      pair_data = s_data[i]; pair_last = (i == s_n - 1);
      while (!pair_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      pair_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk({tag, " R2 single done"}, n_done - d0, 1);
    chk({tag, " R9 fail flag"}, fail, e_fail);
    if (e_fail) chk({tag, " R9 fail_addr"}, fail_addr, e_faddr);
    chk({tag, " R4 unprog flag"}, unprog, e_unp);
    if (e_unp) chk({tag, " R4 unprog_addr"}, unprog_addr, e_uaddr);
    for (int d = 0; d < ND; d++)
      chk({tag, $sformatf(" R3 R7 R11 pulses dev%0d", d)}, pulses[d] - p0[d], e_pul[d]);
    begin
      int bad = 0;
      for (int d = 0; d < ND; d++)
        for (int a = 0; a < NLOC; a++) if (mem[d][a] !== exm[d][a]) bad++;
      chk({tag, " R11 image"}, bad, 0);
    end
    chk({tag, " R5 setup/stability"}, v_setup, 0);
    chk({tag, " R6 pulse width"}, v_width, 0);
    chk({tag, " R7 single select"}, v_sel, 0);
    chk({tag, " R8 recovery"}, v_rec, 0);
    chk({tag, " R10 bus release"}, v_bus, 0);
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h51ed);
    for (int d = 0; d < ND; d++) begin
      pulses[d] = 0; low_cnt[d] = 0;
      for (int a = 0; a < NLOC; a++) begin
        mem[d][a] = '1; exm[d][a] = '1; stuck[d][a] = '0;
      end
    end
    stuck[1][9] = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ce_n", prom_ce_n, 2'b11);
    chk("R1 oe_n", prom_oe_n, 1);
    chk("R1 vpp/drive", {vpp_en, prom_dq_oe}, 0);
    chk("R1 status", {busy, done, fail, unprog}, 0);

    // directed: program, skip, refuse 0->1, other device
    new_session();
    add_pair(0, 6'd5, 8'hA5);
    add_pair(0, 6'd5, 8'hA5);
    add_pair(0, 6'd5, 8'h5A);
    add_pair(1, 6'd5, 8'h3C);
    run_session("S1");

    // stuck bit: verify mismatch, sequence continues
    new_session();
    add_pair(1, 6'd9, 8'hFE);
    add_pair(0, 6'd63, 8'h00);
    add_pair(1, 6'd9, 8'hFE);
    add_pair(0, 6'd2, 8'hF0);
    run_session("S2");

    // single skipped record: no pulse at all, flags cleared by start (R2)
    new_session();
    add_pair(0, 6'd5, 8'hA5);
    run_session("S3");

    // random record stream
    new_session();
    for (int i = 0; i < 40; i++) begin
      logic d; logic [AW-1:0] a; logic [DW-1:0] w; int k;
      d = 1'($urandom); a = AW'($urandom); k = $urandom % 4;
      case (k)
        0: w = exm[d][a];
        1: w = exm[d][a] & DW'($urandom);
        2: w = DW'($urandom);
        default: w = exm[d][a] & DW'($urandom) & DW'($urandom);
      endcase
      add_pair(d, a, w);
    end
    run_session("S4");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule